// File: doc/BRIEF.md
# Dual-Half General Purpose Timer

This block is a memory-mapped timer built from two 16-bit halves, A and B, that software joins into a single 32-bit counter. A simple register port (write strobe, byte address, 32-bit write data, combinational read data) programs it. It drives one level interrupt and a one-cycle pulse output meant to start an ADC conversion.

Two configurations run. In the wide count-down configuration the counter is loaded from the two load halves and counts down once per clock. On each timeout it either reloads or stops. In the seconds configuration a divider of the system clock produces a one-second tick, a seconds counter advances on each tick, and the new value is compared against the 32-bit match value built from the two match halves. Interrupt causes collect in a raw status register, gated by a mask and cleared by writing ones.

Top module: `gp_timer`

## Requirements
- R1: After a synchronous reset every register reads zero, the timer is stopped, and `irq_o` and `trig_o` are low.
- R2: With configuration 0 (register 0x00), a control write (0x0C) that changes bit 0 from 0 to 1 loads the counter with {load B, load A} (0x2C, 0x28). While running, the counter drops by one each clock. The current value reads at 0x48.
- R3: A timeout occurs on the clock where the running counter is zero. It sets raw status bit 0 (0x1C). When mode-A bit 0 (0x04) is clear, the same edge reloads the counter, so a load value L gives a period of L+1 clocks.
- R4: When mode-A bit 0 is set (one-shot), a timeout stops the timer and the counter stays at zero with no later timeout.
- R5: Each timeout gives a `trig_o` pulse of exactly one clock, one cycle after the timeout, when control bit 5 is set. With bit 5 clear, `trig_o` stays low.
- R6: A control write that changes bit 0 from 1 to 0 freezes the counter value.
- R7: With configuration 1, starting the timer clears the seconds counter. Every RTC_DIV clocks the counter then advances by one, and it reads at 0x48. Raw status bit 2 is set on the edge where the new count equals {match B, match A} (0x34, 0x30).
- R8: The interrupt mask (0x18) keeps only the bits of 0x77 of a write. Address 0x20 reads raw status AND mask, and `irq_o` is high exactly while that value is nonzero.
- R9: Writing ones to 0x24 clears those raw status bits. A cause that sets a bit on the same edge wins over its clear.
- R10: While the configuration is below 4, a write to load A or match A also writes the upper 16 bits into the B half, and a read returns {B half, A half}. From configuration 4 upward the B half is neither written by it nor returned, and the upper 16 bits read zero.
- R11: Load B, match B, both prescale registers (0x38, 0x3C) and both prescale-match registers (0x40, 0x44) each store and return the low 16 bits written, per half, independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt, masked status nonzero |
| trig_o | output | 1 | One-clock ADC start pulse on timeout |

## Verification
The assertions watch four things on every cycle. A trigger pulse must be backed by an enabled trigger bit and a set timeout status. The interrupt may change only when status or mask change. A running count-down counter must step by exactly one. The seconds counter may only hold or advance by one. The reload period for a sweep of small load values, the one-shot stop, the exact tick and match cycle of the seconds mode, the mask width, set-over-clear priority and the split-view register readback depend on chosen stimulus, so only the bench's scenarios can show them.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int AW     = 8;
    localparam int CTRL_W = 16;
    localparam int MODE_W = 4;
    localparam int ST_W   = 8;
    localparam int CFG_W  = 3;

    // register offsets
    localparam logic [AW-1:0] A_CFG     = 8'h00;
    localparam logic [AW-1:0] A_MODE_A  = 8'h04;
    localparam logic [AW-1:0] A_MODE_B  = 8'h08;
    localparam logic [AW-1:0] A_CTRL    = 8'h0C;
    localparam logic [AW-1:0] A_IMASK   = 8'h18;
    localparam logic [AW-1:0] A_RAW     = 8'h1C;
    localparam logic [AW-1:0] A_MSK_ST  = 8'h20;
    localparam logic [AW-1:0] A_ICLR    = 8'h24;
    localparam logic [AW-1:0] A_LOAD_A  = 8'h28;
    localparam logic [AW-1:0] A_LOAD_B  = 8'h2C;
    localparam logic [AW-1:0] A_MATCH_A = 8'h30;
    localparam logic [AW-1:0] A_MATCH_B = 8'h34;
    localparam logic [AW-1:0] A_PRE_A   = 8'h38;
    localparam logic [AW-1:0] A_PRE_B   = 8'h3C;
    localparam logic [AW-1:0] A_PMT_A   = 8'h40;
    localparam logic [AW-1:0] A_PMT_B   = 8'h44;
    localparam logic [AW-1:0] A_VALUE   = 8'h48;

    localparam logic [ST_W-1:0] IMASK_KEEP = 8'h77;
    localparam int ST_TIMEOUT  = 0;
    localparam int ST_SECS_HIT = 2;

    localparam int CB_RUN_A   = 0;
    localparam int CB_TRIG    = 5;
    localparam int MB_ONESHOT = 0;

    localparam logic [CFG_W-1:0] SPLIT_CFG_MIN = 3'd4;

    typedef enum logic [CFG_W-1:0] {
        CFG_WIDE_DOWN = 3'd0,
        CFG_SECONDS   = 3'd1
    } cfg_e;

    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic              one_shot;
        logic              trig_en;
        logic [WORD_W-1:0] reload;
        logic [WORD_W-1:0] match;
    } tmr_ctl_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic mask_wr;
        logic clr_wr;
    } bus_evt_t;

    function automatic logic [WORD_W-1:0] join_halves(input logic [HALF_W-1:0] hi,
                                                      input logic [HALF_W-1:0] lo);
        return {hi, lo};
    endfunction

    function automatic logic wide_view(input logic [CFG_W-1:0] cfg);
        return cfg < SPLIT_CFG_MIN;
    endfunction

endpackage

// File: rtl/gpt_regs.sv
module gpt_regs
    import gpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ST_W-1:0]   raw,
    input  logic [ST_W-1:0]   mask,
    input  logic [WORD_W-1:0] value,
    output logic [WORD_W-1:0] rdata,
    output tmr_ctl_t          ctl,
    output bus_evt_t          evt
);

    localparam int HALVES = 2;

    logic [CFG_W-1:0]  cfg_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [MODE_W-1:0] mode_q  [HALVES];
    logic [HALF_W-1:0] load_q  [HALVES];
    logic [HALF_W-1:0] match_q [HALVES];
    logic [HALF_W-1:0] pre_q   [HALVES];
    logic [HALF_W-1:0] pmt_q   [HALVES];

    logic [HALF_W-1:0] wlo, whi;
    logic              wide;

    assign wlo  = wdata[HALF_W-1:0];
    assign whi  = wdata[WORD_W-1:HALF_W];
    assign wide = wide_view(cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            ctrl_q <= '0;
            for (int h = 0; h < HALVES; h++) begin
                mode_q[h]  <= '0;
                load_q[h]  <= '0;
                match_q[h] <= '0;
                pre_q[h]   <= '0;
                pmt_q[h]   <= '0;
            end
        end else if (wr_en) begin
            case (addr)
                A_CFG:     cfg_q      <= wdata[CFG_W-1:0];
                A_MODE_A:  mode_q[0]  <= wdata[MODE_W-1:0];
                A_MODE_B:  mode_q[1]  <= wdata[MODE_W-1:0];
                A_CTRL:    ctrl_q     <= wdata[CTRL_W-1:0];
                A_LOAD_A: begin
                    load_q[0] <= wlo;
                    if (wide) load_q[1] <= whi;
                end
                A_LOAD_B:  load_q[1]  <= wlo;
                A_MATCH_A: begin
                    match_q[0] <= wlo;
                    if (wide) match_q[1] <= whi;
                end
                A_MATCH_B: match_q[1] <= wlo;
                A_PRE_A:   pre_q[0]   <= wlo;
                A_PRE_B:   pre_q[1]   <= wlo;
                A_PMT_A:   pmt_q[0]   <= wlo;
                A_PMT_B:   pmt_q[1]   <= wlo;
                default: ;
            endcase
        end
    end

    logic ctrl_hit;
    assign ctrl_hit = wr_en && (addr == A_CTRL);

    always_comb begin
        evt.start   = ctrl_hit &&  wdata[CB_RUN_A] && !ctrl_q[CB_RUN_A];
        evt.stop    = ctrl_hit && !wdata[CB_RUN_A] &&  ctrl_q[CB_RUN_A];
        evt.mask_wr = wr_en && (addr == A_IMASK);
        evt.clr_wr  = wr_en && (addr == A_ICLR);
    end

    always_comb begin
        ctl.cfg      = cfg_q;
        ctl.one_shot = mode_q[0][MB_ONESHOT];
        ctl.trig_en  = ctrl_q[CB_TRIG];
        ctl.reload   = join_halves(load_q[1], load_q[0]);
        ctl.match    = join_halves(match_q[1], match_q[0]);
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CFG:     rdata = WORD_W'(cfg_q);
            A_MODE_A:  rdata = WORD_W'(mode_q[0]);
            A_MODE_B:  rdata = WORD_W'(mode_q[1]);
            A_CTRL:    rdata = WORD_W'(ctrl_q);
            A_IMASK:   rdata = WORD_W'(mask);
            A_RAW:     rdata = WORD_W'(raw);
            A_MSK_ST:  rdata = WORD_W'(raw & mask);
            A_LOAD_A:  rdata = join_halves(wide ? load_q[1] : '0, load_q[0]);
            A_LOAD_B:  rdata = WORD_W'(load_q[1]);
            A_MATCH_A: rdata = join_halves(wide ? match_q[1] : '0, match_q[0]);
            A_MATCH_B: rdata = WORD_W'(match_q[1]);
            A_PRE_A:   rdata = WORD_W'(pre_q[0]);
            A_PRE_B:   rdata = WORD_W'(pre_q[1]);
            A_PMT_A:   rdata = WORD_W'(pmt_q[0]);
            A_PMT_B:   rdata = WORD_W'(pmt_q[1]);
            A_VALUE:   rdata = value;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpt_countdown.sv
module gpt_countdown
    import gpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              start,
    input  logic              stop,
    input  logic              one_shot,
    input  logic [WORD_W-1:0] reload,
    output logic [WORD_W-1:0] count,
    output logic              running,
    output logic              timeout
);

    assign timeout = running && enable && (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            running <= 1'b0;
        end else if (start) begin
            running <= 1'b1;
            count   <= reload;
        end else if (stop) begin
            running <= 1'b0;
        end else if (timeout) begin
            if (one_shot) running <= 1'b0;
            else          count   <= reload;
        end else if (running && enable) begin
            count <= count - WORD_W'(1);
        end
    end

endmodule

// File: rtl/gpt_seconds.sv
module gpt_seconds
    import gpt_pkg::*;
#(
    parameter int DIV = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              start,
    input  logic              stop,
    input  logic [WORD_W-1:0] match,
    output logic [WORD_W-1:0] secs,
    output logic              running,
    output logic              hit
);

    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0]     div_q;
    logic              tick;
    logic [WORD_W-1:0] secs_nx;

    assign tick    = running && enable && (div_q == LAST);
    assign secs_nx = secs + WORD_W'(1);
    assign hit     = tick && (secs_nx == match);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            secs    <= '0;
            running <= 1'b0;
        end else if (start) begin
            div_q   <= '0;
            secs    <= '0;
            running <= 1'b1;
        end else if (stop) begin
            running <= 1'b0;
        end else if (tick) begin
            div_q <= '0;
            secs  <= secs_nx;
        end else if (running && enable) begin
            div_q <= div_q + DW'(1);
        end
    end

endmodule

// File: rtl/gpt_status.sv
module gpt_status
    import gpt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [ST_W-1:0] set_vec,
    input  logic            clr_wr,
    input  logic [ST_W-1:0] clr_val,
    input  logic            mask_wr,
    input  logic [ST_W-1:0] mask_val,
    output logic [ST_W-1:0] raw,
    output logic [ST_W-1:0] mask,
    output logic            irq
);

    logic [ST_W-1:0] clr_eff;
    assign clr_eff = clr_wr ? clr_val : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= (raw & ~clr_eff) | set_vec;
            if (mask_wr) mask <= mask_val & IMASK_KEEP;
        end
    end

    assign irq = |(raw & mask);

endmodule

// File: rtl/gp_timer.sv
module gp_timer
    import gpt_pkg::*;
#(
    parameter int RTC_DIV = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              trig_o
);

    tmr_ctl_t          ctl;
    bus_evt_t          evt;
    logic [ST_W-1:0]   raw, mask, set_vec;
    logic [WORD_W-1:0] count, secs, value;
    logic              cnt_running, sec_running, timeout, sec_hit;
    logic              trig_q, trig_en;
    logic [CFG_W-1:0]  cfg;

    assign trig_en = ctl.trig_en;
    assign cfg     = ctl.cfg;

    gpt_regs i_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .raw   (raw),
        .mask  (mask),
        .value (value),
        .rdata (bus_rdata),
        .ctl   (ctl),
        .evt   (evt)
    );

    gpt_countdown i_down (
        .clk      (clk),
        .rst      (rst),
        .enable   (cfg == CFG_WIDE_DOWN),
        .start    (evt.start),
        .stop     (evt.stop),
        .one_shot (ctl.one_shot),
        .reload   (ctl.reload),
        .count    (count),
        .running  (cnt_running),
        .timeout  (timeout)
    );

    gpt_seconds #(.DIV(RTC_DIV)) i_secs (
        .clk     (clk),
        .rst     (rst),
        .enable  (cfg == CFG_SECONDS),
        .start   (evt.start),
        .stop    (evt.stop),
        .match   (ctl.match),
        .secs    (secs),
        .running (sec_running),
        .hit     (sec_hit)
    );

    always_comb begin
        set_vec              = '0;
        set_vec[ST_TIMEOUT]  = timeout;
        set_vec[ST_SECS_HIT] = sec_hit;
    end

    gpt_status i_stat (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr_wr   (evt.clr_wr),
        .clr_val  (bus_wdata[ST_W-1:0]),
        .mask_wr  (evt.mask_wr),
        .mask_val (bus_wdata[ST_W-1:0]),
        .raw      (raw),
        .mask     (mask),
        .irq      (irq_o)
    );

    assign value = (cfg == CFG_SECONDS) ? secs : count;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= timeout && trig_en;
    end

    assign trig_o = trig_q;

endmodule

// File: rtl/gpt_checker.sv
module gpt_checker
    import gpt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              trig_o,
    input logic              irq_o,
    input logic              trig_en,
    input logic [ST_W-1:0]   raw,
    input logic [ST_W-1:0]   mask,
    input logic [CFG_W-1:0]  cfg,
    input logic              cnt_running,
    input logic [WORD_W-1:0] count,
    input logic              sec_running,
    input logic [WORD_W-1:0] secs
);

    p_trig_needs_enable_r5: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> $past(trig_en));

    p_trig_with_status_r3: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> raw[ST_TIMEOUT]);

    p_irq_follows_status_r8: assert property (@(posedge clk) disable iff (rst)
        ($stable(raw) && $stable(mask)) |-> $stable(irq_o));

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg == CFG_WIDE_DOWN && cnt_running && count != '0 && !bus_wr)
        |=> (count == $past(count) - WORD_W'(1)));

    p_secs_step_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg == CFG_SECONDS && sec_running && !bus_wr)
        |=> (secs == $past(secs) || secs == $past(secs) + WORD_W'(1)));

endmodule

bind gp_timer gpt_checker i_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .trig_o      (trig_o),
    .irq_o       (irq_o),
    .trig_en     (trig_en),
    .raw         (raw),
    .mask        (mask),
    .cfg         (cfg),
    .cnt_running (cnt_running),
    .count       (count),
    .sec_running (sec_running),
    .secs        (secs)
);

// File: tb/test_gp_timer.sv
module test_gp_timer;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, trig_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    gp_timer #(.RTC_DIV(DIV)) i_gp_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .trig_o    (trig_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // write lands on the posedge between two falling edges
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {31'd0, irq_o}, 0);
        chk("R1 trig", {31'd0, trig_o}, 0);
        rd(8'h00, v); chk("R1 cfg", v, 0);
        rd(8'h28, v); chk("R1 load", v, 0);
        rd(8'h1C, v); chk("R1 raw", v, 0);
        rd(8'h48, v); chk("R1 value", v, 0);

        // R8 mask width
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, v); chk("R8 mask keep", v, 32'h77);
        wr(8'h18, 32'h0);

        // R10 / R11 half views
        wr(8'h28, 32'h1234_5678);
        rd(8'h28, v); chk("R10 load wide", v, 32'h1234_5678);
        rd(8'h2C, v); chk("R10 load B", v, 32'h1234);
        wr(8'h30, 32'hA5A5_5A5A);
        rd(8'h34, v); chk("R10 match B", v, 32'hA5A5);
        wr(8'h00, 32'd4);
        rd(8'h28, v); chk("R10 split read", v, 32'h5678);
        wr(8'h28, 32'hFFFF_0001);
        rd(8'h2C, v); chk("R10 B untouched", v, 32'h1234);
        rd(8'h28, v); chk("R10 split lo", v, 32'h0001);
        rd(8'h30, v); chk("R10 match split", v, 32'h5A5A);
        wr(8'h38, 32'h00AB);
        wr(8'h44, 32'h003C);
        wr(8'h34, 32'h0077);
        rd(8'h38, v); chk("R11 pre A", v, 32'hAB);
        rd(8'h3C, v); chk("R11 pre B", v, 32'h0);
        rd(8'h44, v); chk("R11 pmt B", v, 32'h3C);
        rd(8'h40, v); chk("R11 pmt A", v, 32'h0);
        rd(8'h34, v); chk("R11 match B", v, 32'h77);
        wr(8'h00, 32'd0);

        // R2 R3 R5 periodic sweep
        for (int L = 0; L < 7; L++) begin
            wr(8'h04, 32'h0);
            wr(8'h28, L);
            wr(8'h0C, 32'h21);
            rd(8'h48, v); chk("R2 start load", v, L);
            for (int k = 1; k <= L + 2; k++) begin
                @(negedge clk);
                rd(8'h48, v);
                if (k <= L) begin
                    chk("R2 decrement", v, L - k);
                    chk("R5 no early trig", {31'd0, trig_o}, 0);
                end else if (k == L + 1) begin
                    chk("R3 reload", v, L);
                    chk("R5 trig pulse", {31'd0, trig_o}, 1);
                    rd(8'h1C, v2); chk("R3 raw timeout", v2 & 32'h1, 1);
                end else if (L > 0) begin
                    chk("R5 single cycle", {31'd0, trig_o}, 0);
                end
            end
            wr(8'h0C, 32'h0);
            wr(8'h24, 32'h1);
        end

        // R5 trigger disabled
        wr(8'h28, 32'd3);
        wr(8'h0C, 32'h01);
        v2 = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (trig_o) v2 = 1;
        end
        chk("R5 no trig when disabled", v2, 0);
        rd(8'h1C, v); chk("R5 raw still set", v & 32'h1, 1);

        // R6 stop freezes
        wr(8'h28, 32'd50);
        wr(8'h0C, 32'h0);
        wr(8'h0C, 32'h01);
        repeat (3) @(negedge clk);
        wr(8'h0C, 32'h0);
        rd(8'h48, v);
        repeat (5) @(negedge clk);
        rd(8'h48, v2);
        chk("R6 frozen", v2, v);
        chk("R6 moved before stop", (v < 50) ? 1 : 0, 1);
        wr(8'h24, 32'hFF);

        // R4 one-shot
        wr(8'h04, 32'h1);
        wr(8'h28, 32'd4);
        wr(8'h0C, 32'h21);
        repeat (5) @(negedge clk);
        chk("R4 timeout pulse", {31'd0, trig_o}, 1);
        v2 = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            rd(8'h48, v);
            if (trig_o || v != 0) v2 = 1;
        end
        chk("R4 stays stopped at zero", v2, 0);

        // R8 masking of irq
        chk("R8 irq masked off", {31'd0, irq_o}, 0);
        rd(8'h20, v); chk("R8 masked read zero", v, 0);
        wr(8'h18, 32'h1);
        chk("R8 irq on", {31'd0, irq_o}, 1);
        rd(8'h20, v); chk("R8 masked read", v, 1);
        wr(8'h24, 32'h1);
        chk("R9 cleared irq", {31'd0, irq_o}, 0);
        rd(8'h1C, v); chk("R9 raw cleared", v, 0);

        // R9 set wins over clear
        wr(8'h0C, 32'h0);
        wr(8'h04, 32'h0);
        wr(8'h28, 32'd0);
        wr(8'h0C, 32'h01);
        wr(8'h24, 32'h1);
        rd(8'h1C, v); chk("R9 set wins", v & 32'h1, 1);
        wr(8'h0C, 32'h0);
        wr(8'h24, 32'h1);
        rd(8'h1C, v); chk("R9 clear after stop", v, 0);

        // R7 seconds mode
        wr(8'h00, 32'd1);
        wr(8'h30, 32'd3);
        wr(8'h18, 32'h4);
        wr(8'h0C, 32'h01);
        rd(8'h48, v); chk("R7 cleared at start", v, 0);
        for (int k = 1; k <= 17; k++) begin
            @(negedge clk);
            rd(8'h48, v);
            chk("R7 seconds", v, k / DIV);
            rd(8'h1C, v);
            chk("R7 match status", (v >> 2) & 32'h1, (k >= 3 * DIV) ? 1 : 0);
            chk("R7 match irq", {31'd0, irq_o}, (k >= 3 * DIV) ? 1 : 0);
        end
        wr(8'h0C, 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule